// File: doc/BRIEF.md
# Two-Wire Bus Condition Detector with Spike Filter

This block sits between the raw clock and data pins of a two-wire (I2C) target and its protocol engine. Both lines are first synchronized to the system clock. They then pass through a stability filter that accepts a new level only after it has held for a programmable number of clocks, so short noise spikes never reach the engine. From the filtered levels the block produces single-cycle strobes for START, STOP, clock rise and clock fall. It also keeps a flag that says whether the bus is idle.

On the output side, the engine asks for the data line to be pulled low or released. The block applies that request only while the filtered clock is low, and only once a hold interval counted from the filtered clock's falling edge has run out. A data edge made by the target therefore never lands inside the clock's undefined falling region and cannot be read as a START or STOP. Pad drivers and analog hysteresis are outside the block.

Top module: `i2c_line_cond`

## Requirements
- R1: Each filtered level (`scl_flt`, `sda_flt`) takes a new raw level that holds for FILT_LEN or more clock edges. The change shows after the (FILT_LEN+2)-th rising clock edge that samples the new raw level: two edges for synchronization, then FILT_LEN edges of stability.
- R2: A raw pulse that holds for FILT_LEN-1 or fewer sampling edges changes neither filtered level and produces no strobe.
- R3: `start_det` is high for exactly one clock when filtered SDA goes from 1 to 0 while filtered SCL is 1 both before and after the change.
- R4: `stop_det` is high for exactly one clock when filtered SDA goes from 0 to 1 while filtered SCL is 1 both before and after the change.
- R5: `scl_rise` and `scl_fall` are each high for exactly one clock per filtered SCL transition, in the same cycle in which `scl_flt` shows the new level. They are never high together.
- R6: SDA transitions made while filtered SCL is 0 raise neither `start_det` nor `stop_det`.
- R7: `bus_idle` is 1 after reset. It goes to 0 one clock after a `start_det` strobe (a repeated START included) and to 1 one clock after a `stop_det` strobe.
- R8: Let E be the clock edge at which `scl_flt` falls. `sda_oe` takes the value of `sda_oe_req` at edge E+HOLD_CYC+1 and not earlier. Once the hold has run out and SCL stays low, a later request change is applied at the next edge.
- R9: `sda_oe` never changes at an edge where filtered SCL was 1 before the edge. A request made while SCL is high waits.
- R10: While reset is held, and in the first cycle after it is released: `scl_flt`=1, `sda_flt`=1, `bus_idle`=1, `sda_oe`=0, and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw serial clock pin level |
| sda_in | input | 1 | Raw serial data pin level |
| sda_oe_req | input | 1 | Engine request: 1 pulls SDA low, 0 releases it |
| scl_flt | output | 1 | Synchronized, spike-filtered SCL level |
| sda_flt | output | 1 | Synchronized, spike-filtered SDA level |
| start_det | output | 1 | One-cycle START strobe |
| stop_det | output | 1 | One-cycle STOP strobe |
| scl_rise | output | 1 | One-cycle filtered SCL rising strobe |
| scl_fall | output | 1 | One-cycle filtered SCL falling strobe |
| bus_idle | output | 1 | Bus idle flag |
| sda_oe | output | 1 | Hold-delayed SDA pull-down enable to the pad |

## Verification
A filter counter that fails to clear shows up within one transfer: a spike passes to `scl_flt` or `sda_flt`, or a genuine edge comes out at the wrong cycle count, and in either case extra START/STOP strobes appear in the same cycle. A stale previous-level register in the edge stage gives strobes that are two cycles wide, missing, or of the wrong kind at the next filtered transition. A wrong idle flag is visible one clock after the next START or STOP. A bad hold counter moves `sda_oe` off the expected edge E+HOLD_CYC+1 on the very next SCL fall.

// File: rtl/i2c_lc_pkg.sv
// Package: shared constants for the two-wire bus condition detector.
// Assumes the two lines are filtered by identical instances indexed here.
package i2c_lc_pkg;
    localparam int NUM_LINES = 2;
    localparam int LINE_SCL  = 0;
    localparam int LINE_SDA  = 1;

    // Counter width able to hold values 0..max_val (at least one bit).
    function automatic int cnt_width(input int max_val);
        return (max_val > 1) ? $clog2(max_val + 1) : 1;
    endfunction
endpackage

// File: rtl/i2c_lc_filter.sv
// Module: i2c_lc_filter
// Two-flop synchronizer followed by a stability filter. The filtered level
// takes a new raw level only after the synchronized value has differed from
// it for FILT_LEN consecutive clocks. Assumes FILT_LEN >= 1 and an idle-high
// line (all state resets to 1).
module i2c_lc_filter #(
    parameter int FILT_LEN = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    output logic level_out
);
    import i2c_lc_pkg::*;

    localparam int CW = cnt_width(FILT_LEN - 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic          sync1, sync2;
    logic [CW-1:0] run_cnt;
    logic          level_q;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= raw_in;
            sync2 <= sync1;
        end
    end

    // Count consecutive disagreeing samples and accept the level at FILT_LEN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level_q <= 1'b1;
        end else if (sync2 == level_q) begin
            run_cnt <= '0;
        end else if (run_cnt == LAST) begin
            run_cnt <= '0;
            level_q <= sync2;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign level_out = level_q;
endmodule

// File: rtl/i2c_lc_detect.sv
// Module: i2c_lc_detect
// Turns the filtered clock and data levels into single-cycle START, STOP,
// clock-rise and clock-fall strobes, and keeps the bus idle flag. Assumes
// both inputs are registered, glitch-free levels.
module i2c_lc_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_stb,
    output logic stop_stb,
    output logic rise_stb,
    output logic fall_stb,
    output logic idle
);
    logic scl_q, sda_q, idle_q;

    // Remember the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Classify the current transition; SCL must be high on both sides for a condition.
    always_comb begin
        start_stb = scl_q & scl_f & sda_q & ~sda_f;
        stop_stb  = scl_q & scl_f & ~sda_q & sda_f;
        rise_stb  = ~scl_q & scl_f;
        fall_stb  = scl_q & ~scl_f;
    end

    // Idle flag: cleared by START, set by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_q <= 1'b1;
        else if (start_stb)
            idle_q <= 1'b0;
        else if (stop_stb)
            idle_q <= 1'b1;
    end

    assign idle = idle_q;
endmodule

// File: rtl/i2c_lc_hold.sv
// Module: i2c_lc_hold
// Applies the engine's SDA pull-down request only while filtered SCL is low
// and HOLD_CYC clocks after the filtered falling edge have passed. Assumes
// HOLD_CYC >= 1 and a one-cycle fall strobe aligned with the level change.
module i2c_lc_hold #(
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic fall_stb,
    input  logic oe_req,
    output logic oe
);
    import i2c_lc_pkg::*;

    localparam int HW = cnt_width(HOLD_CYC);
    localparam logic [HW-1:0] LOAD = HW'(HOLD_CYC - 1);

    logic [HW-1:0] hold_cnt;
    logic          oe_q;
    logic          open_win;

    // The output may move only in a low SCL phase whose hold time has run out.
    assign open_win = ~scl_f & ~fall_stb & (hold_cnt == '0);

    // Restart the hold interval on every falling edge, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt <= '0;
        else if (fall_stb)
            hold_cnt <= LOAD;
        else if (hold_cnt != '0)
            hold_cnt <= hold_cnt - 1'b1;
    end

    // Take the requested enable when the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            oe_q <= 1'b0;
        else if (open_win)
            oe_q <= oe_req;
    end

    assign oe = oe_q;
endmodule

// File: rtl/i2c_line_cond.sv
// Module: i2c_line_cond
// Top of the bus condition detector: filters both raw lines, detects bus
// conditions and clock edges, and delays the SDA pull-down enable past the
// SCL falling edge. Assumes raw pins are asynchronous and idle high.
module i2c_line_cond #(
    parameter int FILT_LEN = 7,
    parameter int HOLD_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sda_oe_req,
    output logic scl_flt,
    output logic sda_flt,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_idle,
    output logic sda_oe
);
    import i2c_lc_pkg::*;

    logic [NUM_LINES-1:0] raw_vec;
    logic [NUM_LINES-1:0] flt_vec;

    assign raw_vec[LINE_SCL] = scl_in;
    assign raw_vec[LINE_SDA] = sda_in;

    // One identical filter per bus line.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2c_lc_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw_in    (raw_vec[g]),
            .level_out (flt_vec[g])
        );
    end

    assign scl_flt = flt_vec[LINE_SCL];
    assign sda_flt = flt_vec[LINE_SDA];

    i2c_lc_detect u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_flt),
        .sda_f     (sda_flt),
        .start_stb (start_det),
        .stop_stb  (stop_det),
        .rise_stb  (scl_rise),
        .fall_stb  (scl_fall),
        .idle      (bus_idle)
    );

    i2c_lc_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_flt),
        .fall_stb (scl_fall),
        .oe_req   (sda_oe_req),
        .oe       (sda_oe)
    );
endmodule

// File: rtl/i2c_line_cond_chk.sv
// Module: i2c_line_cond_chk
// Property checker bound to i2c_line_cond. Tracks clocks since the last
// filtered SCL fall with a saturating counter to check the hold window.
module i2c_line_cond_chk #(
    parameter int HOLD_CYC = 40
) (
    input logic clk,
    input logic rst_n,
    input logic scl_flt,
    input logic start_det,
    input logic stop_det,
    input logic scl_rise,
    input logic scl_fall,
    input logic bus_idle,
    input logic sda_oe
);
    localparam int SW = $clog2(HOLD_CYC + 2) + 1;
    localparam logic [SW-1:0] SAT = SW'(HOLD_CYC + 1);

    logic [SW-1:0] since_fall;

    // Clocks elapsed since the fall strobe was seen, saturating at HOLD_CYC+1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_fall <= SAT;
        else if (scl_fall)
            since_fall <= SW'(1);
        else if (since_fall != SAT)
            since_fall <= since_fall + 1'b1;
    end

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !start_det); // R3
    AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !stop_det); // R4
    AST_COND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det)); // R3
    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({scl_rise, scl_fall})); // R5
    AST_COND_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_det || stop_det) |-> scl_flt); // R6
    AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !bus_idle); // R7
    AST_IDLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> bus_idle); // R7
    AST_OE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (since_fall >= SAT)); // R8
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_flt)); // R9
endmodule

bind i2c_line_cond i2c_line_cond_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_flt   (scl_flt),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_idle  (bus_idle),
    .sda_oe    (sda_oe)
);

// File: tb/test_i2c_line_cond.sv
module test_i2c_line_cond;
    localparam int F = 4;
    localparam int H = 10;
    localparam int L = 10;
    localparam int NSTEP = 23;

    typedef struct packed {
        logic       scl;
        logic       sda;
        logic [7:0] w;
        logic [7:0] st;
        logic [7:0] sp;
        logic [7:0] ri;
        logic [7:0] fa;
        logic       idle;
        logic       sclf;
        logic       sdaf;
    } step_t;

    // scl, sda, width, cumulative start/stop/rise/fall, idle, filtered scl/sda
    localparam step_t STEPS [NSTEP] = '{
        '{1,1,L,  0,0,0,0, 1,1,1},
        '{1,0,F-1,0,0,0,0, 1,1,1},
        '{1,1,L,  0,0,0,0, 1,1,1},
        '{1,0,L,  1,0,0,0, 0,1,0},
        '{0,0,L,  1,0,0,1, 0,0,0},
        '{1,0,F-1,1,0,0,1, 0,0,0},
        '{0,0,L,  1,0,0,1, 0,0,0},
        '{0,1,L,  1,0,0,1, 0,0,1},
        '{1,1,L,  1,0,1,1, 0,1,1},
        '{0,1,L,  1,0,1,2, 0,0,1},
        '{0,0,L,  1,0,1,2, 0,0,0},
        '{1,0,L,  1,0,2,2, 0,1,0},
        '{1,1,L,  1,1,2,2, 1,1,1},
        '{1,0,F,  1,1,2,2, 1,1,1},
        '{1,1,L,  2,2,2,2, 1,1,1},
        '{1,0,L,  3,2,2,2, 0,1,0},
        '{0,0,L,  3,2,2,3, 0,0,0},
        '{0,1,L,  3,2,2,3, 0,0,1},
        '{1,1,L,  3,2,3,3, 0,1,1},
        '{1,0,L,  4,2,3,3, 0,1,0},
        '{0,0,L,  4,2,3,4, 0,0,0},
        '{1,0,L,  4,2,4,4, 0,1,0},
        '{1,1,L,  4,3,4,4, 1,1,1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1, sda_oe_req = 1'b0;
    logic scl_flt, sda_flt, start_det, stop_det, scl_rise, scl_fall, bus_idle, sda_oe;

    int total = 0, bad = 0, cyc = 0;
    int n_st = 0, n_sp = 0, n_ri = 0, n_fa = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    i2c_line_cond #(.FILT_LEN(F), .HOLD_CYC(H)) i_i2c_line_cond (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_oe_req(sda_oe_req), .scl_flt(scl_flt), .sda_flt(sda_flt),
        .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .bus_idle(bus_idle), .sda_oe(sda_oe)
    );

    // Count strobe cycles away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            n_st += int'(start_det);
            n_sp += int'(stop_det);
            n_ri += int'(scl_rise);
            n_fa += int'(scl_fall);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            total++; bad++;
            $display("FAIL watchdog: act=%0d exp<=50000 cycles", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 scl_flt", int'(scl_flt), 1);
        chk("R10 sda_flt", int'(sda_flt), 1);
        chk("R10 bus_idle", int'(bus_idle), 1);
        chk("R10 sda_oe", int'(sda_oe), 0);
        chk("R10 strobes", int'({start_det, stop_det, scl_rise, scl_fall}), 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NSTEP; i++) begin
            scl_in = STEPS[i].scl;
            sda_in = STEPS[i].sda;
            edges(int'(STEPS[i].w));
            chk($sformatf("R3 start count step %0d", i), n_st, int'(STEPS[i].st));
            chk($sformatf("R4 stop count step %0d", i), n_sp, int'(STEPS[i].sp));
            chk($sformatf("R5 rise count step %0d", i), n_ri, int'(STEPS[i].ri));
            chk($sformatf("R5 fall count step %0d", i), n_fa, int'(STEPS[i].fa));
            chk($sformatf("R7 idle step %0d", i), int'(bus_idle), int'(STEPS[i].idle));
            chk($sformatf("R2 scl_flt step %0d", i), int'(scl_flt), int'(STEPS[i].sclf));
            chk($sformatf("R6 sda_flt step %0d", i), int'(sda_flt), int'(STEPS[i].sdaf));
        end

        // R9: request while SCL high is held back
        sda_oe_req = 1'b1;
        edges(20);
        chk("R9 oe held while scl high", int'(sda_oe), 0);

        // R1 exact latency, R8 exact hold
        scl_in = 1'b0;
        edges(F + 1);
        chk("R1 scl_flt before latency", int'(scl_flt), 1);
        edges(1);
        chk("R1 scl_flt after latency", int'(scl_flt), 0);
        chk("R5 fall strobe aligned", int'(scl_fall), 1);
        edges(H);
        chk("R8 oe not before hold end", int'(sda_oe), 0);
        edges(1);
        chk("R8 oe at hold end", int'(sda_oe), 1);

        // R8: after hold expiry a new request applies at the next edge
        sda_oe_req = 1'b0;
        edges(1);
        chk("R8 oe prompt release", int'(sda_oe), 0);

        // R9: SCL high again, request change waits
        scl_in = 1'b1;
        edges(F + 4);
        sda_oe_req = 1'b1;
        edges(10);
        chk("R9 oe unchanged with scl high", int'(sda_oe), 0);

        // R8: next fall restarts the hold
        scl_in = 1'b0;
        edges(F + 2 + H);
        chk("R8 second hold not expired", int'(sda_oe), 0);
        edges(1);
        chk("R8 second hold expired", int'(sda_oe), 1);

        // R10: reset mid-operation
        rst_n = 1'b0;
        edges(2);
        chk("R10 reset oe", int'(sda_oe), 0);
        chk("R10 reset idle", int'(bus_idle), 1);
        chk("R10 reset scl_flt", int'(scl_flt), 1);
        chk("R10 reset strobes", int'({start_det, stop_det, scl_rise, scl_fall}), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule